// File: doc/BRIEF.md
# Dual-Channel Phase-Frequency Detector with Lock Status

This block compares one reference-divider pulse train against two channel-divider pulse trains. The comparison runs in the oscillator clock domain, and every pulse is taken to be synchronous to that clock. For each channel it produces a pair of pump-request flags, raise and lower, that drive an external charge pump. A pump-direction control can swap the two flags. The detector has no dead zone: any phase error, including zero, gives a pulse of at least one clock on both flags.

Each channel also runs a lock qualifier. A channel is declared locked only when several reference cycles in a row each compare within a window of a few oscillator periods. A single status pin then reports either a chosen combination of the lock flags or, in test mode, one of several internal divider and clock signals. Which one it reports depends on the channel standby bits and a two-bit selector.

Top module: `dual_pfd_lock`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all pump flags clear and both lock counts clear. After reset, a channel that is not in standby reports `lock_out` = 0.
- R2: A rising edge of `ref_in`, sampled at a clock edge, sets the channel's raise flag after that edge. A rising edge of `fb_in[i]` sets its lower flag in the same way. Channel 1 is bit 0 and channel 2 is bit 1.
- R3: When both flags of a channel are set, both clear after the next clock edge. An edge that arrives in that same cycle sets its flag again. Coincident edges therefore give a one-cycle pulse on both flags.
- R4: With `pol_rev` = 0, `up_out` carries the raise flag and `dn_out` carries the lower flag. With `pol_rev` = 1 the two are swapped.
- R5: A comparison is good when the number of clock cycles with exactly one flag set is below `WIN_CYCLES` (default 2). `lock_out[i]` rises once more than `GOOD_RUNS` (default 3) good comparisons have occurred in a row.
- R6: A comparison with an error of `WIN_CYCLES` or more clears the run of good comparisons at once. So does a single flag held for that long with no matching edge. `lock_out[i]` drops after that edge.
- R7: While `stby[i]` is high, that channel's pump flags are cleared at each edge and its counts are cleared. Its `lock_out[i]` reads 1.
- R8: With `test_en` = 0, `ld_code` = 00 gives `ld_out` = 0. Otherwise `ld_out` is the AND of the channels selected: bit 1 selects channel 1 and bit 0 selects channel 2. A channel in standby counts as 1.
- R9: With `test_en` = 1, the value of `stby` selects the test signal. For `stby` = 10 the codes 00/01/10/11 give 0, `pre_tap[1]`, `fb_in[1]` and `ref_in`. For `stby` = 01 they give the quarter-rate tap, `pre_tap[0]`, `fb_in[0]` and the half-rate tap. For `stby` = 00 or 11 the output is 0.
- R10: The half-rate tap is 0 after reset and toggles on every clock edge. The quarter-rate tap is 0 after reset and toggles on every second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Reference-divider pulse |
| fb_in | input | 2 | Channel-divider pulses (bit 0 = channel 1) |
| pre_tap | input | 2 | Prescaler output taps shown in test mode |
| test_en | input | 1 | Status pin shows test signals |
| pol_rev | input | 1 | Swap raise/lower pump direction |
| stby | input | 2 | Channel standby (bit 0 = channel 1) |
| ld_code | input | 2 | Status selector |
| up_out | output | 2 | Pump raise request per channel |
| dn_out | output | 2 | Pump lower request per channel |
| lock_out | output | 2 | Per-channel lock flag |
| ld_out | output | 1 | Status pin |

## Verification
Two events can fall in the same cycle. One is the clearing of a channel's two set flags. The other is a fresh rising edge that would set one of those flags again. The bench provokes this by running the reference with a period of two clocks and the channel edge one clock behind it, so every new reference edge lands in the clearing cycle. A behavioural model, compared on every clock, then judges whether the new pulse survives and whether the comparison that just ended still counts as good.

// File: rtl/pfd_lock_pkg.sv
// Shared types for the dual phase detector.
// Assumes two channels; the status table is defined only for two.
package pfd_lock_pkg;
    localparam int NCH = 2;

    // Meaning of the two-bit status selector in normal mode
    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_CH2  = 2'b01,
        SEL_CH1  = 2'b10,
        SEL_BOTH = 2'b11
    } ld_sel_e;
endpackage

// File: rtl/pfd_pair_core.sv
// Edge-driven phase-frequency core for one channel.
// Sets raise/lower on the rising-edge strobes and clears both one clock
// after they coincide. A held channel keeps both flags clear.
// Assumes the strobes are single-cycle and synchronous to clk.
module pfd_pair_core (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic pol_rev,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic up_raw,
    output logic dn_raw,
    output logic pump_up,
    output logic pump_dn
);
    logic coin;

    assign coin = up_raw & dn_raw;

    // Flag update: a coincidence clears both, a new edge sets its flag
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            up_raw <= 1'b0;
            dn_raw <= 1'b0;
        end else begin
            up_raw <= (up_raw & ~coin) | ref_rise;
            dn_raw <= (dn_raw & ~coin) | fb_rise;
        end
    end

    // Pump direction mapping
    always_comb begin
        pump_up = pol_rev ? dn_raw : up_raw;
        pump_dn = pol_rev ? up_raw : dn_raw;
    end
endmodule

// File: rtl/lock_qualifier.sv
// Lock qualifier for one channel.
// Counts the cycles in which exactly one flag is set; at each coincidence
// the count decides whether the comparison was good. Lock is declared
// once more than GOOD_RUNS good comparisons have occurred in a row.
// Assumes the flags come from pfd_pair_core.
module lock_qualifier #(
    parameter int WIN_CYCLES = 2,
    parameter int GOOD_RUNS  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic up_raw,
    input  logic dn_raw,
    output logic locked
);
    localparam int EW = $clog2(WIN_CYCLES + 1);
    localparam int SW = $clog2(GOOD_RUNS + 2);
    localparam logic [EW-1:0] ERR_LIM = EW'(WIN_CYCLES);
    localparam logic [EW-1:0] ERR_ONE = EW'(1);
    localparam logic [SW-1:0] RUN_TOP = SW'(GOOD_RUNS + 1);

    logic [EW-1:0] err_cnt;
    logic [SW-1:0] run_cnt;

    // Error width measurement and run counting
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            err_cnt <= '0;
            run_cnt <= '0;
        end else if (up_raw && dn_raw) begin
            err_cnt <= '0;
            if (err_cnt < ERR_LIM) begin
                if (run_cnt != RUN_TOP) run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= '0;
            end
        end else if (up_raw != dn_raw) begin
            if (err_cnt != ERR_LIM) err_cnt <= err_cnt + 1'b1;
            if (err_cnt >= ERR_LIM - ERR_ONE) run_cnt <= '0;
        end
    end

    // A held channel reports locked
    assign locked = hold | (run_cnt == RUN_TOP);
endmodule

// File: rtl/test_taps.sv
// Divided copies of the oscillator clock, shown on the status pin in test mode.
// Assumes nothing beyond the clock and reset.
module test_taps #(
    parameter int TAP_BITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic half,
    output logic quarter
);
    logic [TAP_BITS-1:0] div_cnt;

    // Free-running divider counter
    always_ff @(posedge clk) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + 1'b1;
    end

    assign half    = div_cnt[0];
    assign quarter = div_cnt[1];
endmodule

// File: rtl/ld_select.sv
// Status-pin selector. In normal mode it combines the lock flags as the
// selector asks. In test mode it routes one test signal chosen by the
// standby bits and the selector. Assumes eff_lock already reads 1 for
// channels in standby.
module ld_select
    import pfd_lock_pkg::*;
(
    input  logic           test_en,
    input  logic [NCH-1:0] stby,
    input  logic [1:0]     ld_code,
    input  logic [NCH-1:0] eff_lock,
    input  logic           ref_in,
    input  logic [NCH-1:0] fb_in,
    input  logic [NCH-1:0] pre_tap,
    input  logic           half,
    input  logic           quarter,
    output logic           ld
);
    ld_sel_e sel;

    assign sel = ld_sel_e'(ld_code);

    // Output choice
    always_comb begin
        ld = 1'b0;
        if (!test_en) begin
            unique case (sel)
                SEL_NONE: ld = 1'b0;
                SEL_CH2:  ld = eff_lock[1];
                SEL_CH1:  ld = eff_lock[0];
                SEL_BOTH: ld = eff_lock[0] & eff_lock[1];
                default:  ld = 1'b0;
            endcase
        end else begin
            case (stby)
                2'b10: begin
                    case (ld_code)
                        2'b01:   ld = pre_tap[1];
                        2'b10:   ld = fb_in[1];
                        2'b11:   ld = ref_in;
                        default: ld = 1'b0;
                    endcase
                end
                2'b01: begin
                    case (ld_code)
                        2'b00:   ld = quarter;
                        2'b01:   ld = pre_tap[0];
                        2'b10:   ld = fb_in[0];
                        default: ld = half;
                    endcase
                end
                default: ld = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/dual_pfd_lock.sv
// Top of the dual-channel phase detector with lock status.
// Detects rising edges on the reference and channel pulses, runs one
// detector core and one lock qualifier per channel, and drives the status pin.
// Assumes all pulse inputs are synchronous to clk and stay high for at
// least one cycle.
module dual_pfd_lock
    import pfd_lock_pkg::*;
#(
    parameter int WIN_CYCLES = 2,
    parameter int GOOD_RUNS  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_in,
    input  logic [NCH-1:0] fb_in,
    input  logic [NCH-1:0] pre_tap,
    input  logic           test_en,
    input  logic           pol_rev,
    input  logic [NCH-1:0] stby,
    input  logic [1:0]     ld_code,
    output logic [NCH-1:0] up_out,
    output logic [NCH-1:0] dn_out,
    output logic [NCH-1:0] lock_out,
    output logic           ld_out
);
    logic           ref_q;
    logic [NCH-1:0] fb_q;
    logic           ref_rise;
    logic [NCH-1:0] fb_rise;
    logic [NCH-1:0] up_r;
    logic [NCH-1:0] dn_r;
    logic           tap_half;
    logic           tap_quarter;

    // Previous input levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
            fb_q  <= '0;
        end else begin
            ref_q <= ref_in;
            fb_q  <= fb_in;
        end
    end

    assign ref_rise = ref_in & ~ref_q;
    assign fb_rise  = fb_in & ~fb_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pfd_pair_core u_pfd (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold    (stby[i]),
            .pol_rev (pol_rev),
            .ref_rise(ref_rise),
            .fb_rise (fb_rise[i]),
            .up_raw  (up_r[i]),
            .dn_raw  (dn_r[i]),
            .pump_up (up_out[i]),
            .pump_dn (dn_out[i])
        );

        lock_qualifier #(
            .WIN_CYCLES(WIN_CYCLES),
            .GOOD_RUNS (GOOD_RUNS)
        ) u_lock (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (stby[i]),
            .up_raw(up_r[i]),
            .dn_raw(dn_r[i]),
            .locked(lock_out[i])
        );
    end

    test_taps #(.TAP_BITS(2)) u_taps (
        .clk    (clk),
        .rst_n  (rst_n),
        .half   (tap_half),
        .quarter(tap_quarter)
    );

    ld_select u_sel (
        .test_en (test_en),
        .stby    (stby),
        .ld_code (ld_code),
        .eff_lock(lock_out),
        .ref_in  (ref_in),
        .fb_in   (fb_in),
        .pre_tap (pre_tap),
        .half    (tap_half),
        .quarter (tap_quarter),
        .ld      (ld_out)
    );
endmodule

// File: rtl/pfd_lock_chk.sv
// Property checker for dual_pfd_lock, attached by bind.
module pfd_lock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_rise,
    input logic [1:0] fb_rise,
    input logic [1:0] up_r,
    input logic [1:0] dn_r,
    input logic [1:0] up_out,
    input logic [1:0] dn_out,
    input logic [1:0] lock_out,
    input logic [1:0] stby,
    input logic       test_en,
    input logic [1:0] ld_code,
    input logic       ld_out,
    input logic       tap_half
);
    for (genvar i = 0; i < 2; i++) begin : g_p
        // R2
        ref_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_rise && !stby[i]) |=> up_r[i]);
        // R3
        pair_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (up_r[i] && dn_r[i] && !ref_rise && !fb_rise[i]) |=> (!up_r[i] && !dn_r[i]));
        // R7
        stby_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stby[i] |-> lock_out[i]);
        // R7
        stby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stby[i] && $past(stby[i])) |-> (!up_out[i] && !dn_out[i]));
    end

    // R8
    ld_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en && ld_code == 2'b00) |-> !ld_out);
    // R10
    half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tap_half != $past(tap_half)));
endmodule

bind dual_pfd_lock pfd_lock_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_rise(ref_rise),
    .fb_rise (fb_rise),
    .up_r    (up_r),
    .dn_r    (dn_r),
    .up_out  (up_out),
    .dn_out  (dn_out),
    .lock_out(lock_out),
    .stby    (stby),
    .test_en (test_en),
    .ld_code (ld_code),
    .ld_out  (ld_out),
    .tap_half(tap_half)
);

// File: tb/sim_dual_pfd_lock.sv
`timescale 1ns/1ps
module sim_dual_pfd_lock;
    localparam int WIN  = 2;
    localparam int GOOD = 3;
    localparam int WATCHDOG_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic [1:0] fb_in = 2'b00;
    logic [1:0] pre_tap = 2'b00;
    logic       test_en = 1'b0;
    logic       pol_rev = 1'b0;
    logic [1:0] stby = 2'b00;
    logic [1:0] ld_code = 2'b00;
    logic [1:0] up_out, dn_out, lock_out;
    logic       ld_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_pfd_lock #(.WIN_CYCLES(WIN), .GOOD_RUNS(GOOD)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .pre_tap(pre_tap), .test_en(test_en), .pol_rev(pol_rev),
        .stby(stby), .ld_code(ld_code), .up_out(up_out), .dn_out(dn_out),
        .lock_out(lock_out), .ld_out(ld_out)
    );

    // Behavioural reference: pending-edge flags, error widths, good-run counts
    int m_up[2], m_dn[2], m_err[2], m_run[2], m_fbq[2];
    int m_refq, m_cyc;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_up[i] = 0; m_dn[i] = 0; m_err[i] = 0; m_run[i] = 0; m_fbq[i] = 0;
            end
            m_refq = 0;
            m_cyc = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                int re, fe, pair;
                re = (ref_in && !m_refq) ? 1 : 0;
                fe = (fb_in[i] && !m_fbq[i]) ? 1 : 0;
                if (stby[i]) begin
                    m_up[i] = 0; m_dn[i] = 0; m_err[i] = 0; m_run[i] = 0;
                end else begin
                    pair = (m_up[i] && m_dn[i]) ? 1 : 0;
                    if (pair) begin
                        if (m_err[i] < WIN) m_run[i] = (m_run[i] < GOOD + 1) ? m_run[i] + 1 : GOOD + 1;
                        else m_run[i] = 0;
                        m_err[i] = 0;
                    end else if (m_up[i] != m_dn[i]) begin
                        m_err[i] = (m_err[i] < WIN) ? m_err[i] + 1 : WIN;
                        if (m_err[i] >= WIN) m_run[i] = 0;
                    end
                    m_up[i] = ((m_up[i] && !pair) || re) ? 1 : 0;
                    m_dn[i] = ((m_dn[i] && !pair) || fe) ? 1 : 0;
                end
                m_fbq[i] = fb_in[i];
            end
            m_refq = ref_in;
            m_cyc++;
        end
    end

    function automatic bit exp_lock(int i);
        return stby[i] || (m_run[i] > GOOD);
    endfunction

    function automatic bit exp_ld();
        bit l1, l2;
        l1 = exp_lock(0);
        l2 = exp_lock(1);
        if (!test_en) begin
            if (ld_code == 2'b00) return 1'b0;
            return (ld_code[1] ? l1 : 1'b1) & (ld_code[0] ? l2 : 1'b1);
        end
        if (stby == 2'b10) begin
            case (ld_code)
                2'b00: return 1'b0;
                2'b01: return pre_tap[1];
                2'b10: return fb_in[1];
                default: return ref_in;
            endcase
        end
        if (stby == 2'b01) begin
            case (ld_code)
                2'b00: return ((m_cyc / 2) % 2) == 1;
                2'b01: return pre_tap[0];
                2'b10: return fb_in[0];
                default: return (m_cyc % 2) == 1;
            endcase
        end
        return 1'b0;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison of every output against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 2; i++) begin
                int eu, ed;
                eu = pol_rev ? m_dn[i] : m_up[i];
                ed = pol_rev ? m_up[i] : m_dn[i];
                check(pol_rev ? "R4 up_out" : "R2 up_out (R3)", up_out[i], eu);
                check(pol_rev ? "R4 dn_out" : "R2 dn_out (R3)", dn_out[i], ed);
                check(stby[i] ? "R7 lock_out" : "R5 R6 lock_out", lock_out[i], exp_lock(i));
            end
            check(test_en ? "R9 R10 ld_out" : "R8 ld_out", ld_out, exp_ld());
        end
    end

    // Drive n periods of length per; position -1 means no pulse
    task automatic run_periods(int n, int per, int pr, int p1, int p2);
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < per; c++) begin
                @(posedge clk); #1;
                ref_in   = (c == pr);
                fb_in[0] = (c == p1);
                fb_in[1] = (c == p2);
                pre_tap  = 2'(c);
            end
        end
    endtask

    initial begin
        #(WATCHDOG_CYCLES * 5.0);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 up_out", up_out, 0);
        check("R1 dn_out", dn_out, 0);
        check("R1 lock_out", lock_out, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R5: ch1 aligned, ch2 one cycle late
        ld_code = 2'b11;
        run_periods(2, 8, 0, 0, 1);
        @(negedge clk);
        check("R5 not yet locked", lock_out, 2'b00);
        run_periods(6, 8, 0, 0, 1);
        @(negedge clk);
        check("R5 both locked", lock_out, 2'b11);
        check("R8 AND of both", ld_out, 1);

        // R6: ch1 two cycles late breaks its run
        run_periods(2, 8, 0, 2, 1);
        @(negedge clk);
        check("R6 ch1 unlocked", lock_out[0], 0);
        check("R6 ch2 still locked", lock_out[1], 1);
        ld_code = 2'b01;
        @(negedge clk);
        check("R8 ch2 selected", ld_out, 1);

        // Channel leading the reference by one cycle
        ld_code = 2'b10;
        run_periods(7, 8, 2, 1, 2);
        @(negedge clk);
        check("R5 leading fb locks", lock_out[0], 1);

        // R4 reversed pump direction
        pol_rev = 1'b1;
        run_periods(4, 8, 0, 3, 0);
        pol_rev = 1'b0;

        // R6: missing channel pulses
        run_periods(4, 8, 0, -1, 0);
        @(negedge clk);
        check("R6 no fb edge", lock_out[0], 0);

        // R3: new reference edge in the clearing cycle
        run_periods(12, 2, 0, 1, 0);
        @(negedge clk);
        check("R3 fast ref keeps locking", lock_out, 2'b11);

        // R7 R8 standby and selector sweep
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) begin
                stby = 2'(s);
                ld_code = 2'(c);
                run_periods(1, 8, 0, 3, 0);
                @(negedge clk);
                if (s[0]) check("R7 ch1 standby lock", lock_out[0], 1);
                if (s[1]) check("R7 ch2 standby quiet", up_out[1] | dn_out[1], 0);
            end
        end

        // R9 R10 test-mode routing
        test_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) begin
                stby = 2'(s);
                ld_code = 2'(c);
                run_periods(2, 4, 0, 1, 2);
            end
        end
        stby = 2'b01;
        ld_code = 2'b11;
        @(negedge clk);
        begin
            int h0;
            h0 = ld_out;
            @(negedge clk);
            check("R10 half-rate toggles", ld_out, !h0);
        end
        test_en = 1'b0;
        stby = 2'b00;
        run_periods(2, 8, 0, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule